// File: doc/BRIEF.md
# Power-On Start-up Delay Sequencer

This block decides how a device comes out of power-on reset. While the supply is not good it holds the CPU and forces every general-purpose pin into high-impedance input mode. Once power is good it chooses between two paths. In the first, the device parks in a suspend wait until the attached bus wakes it. In the second, it goes straight to a timed hold. The timed hold keeps the CPU stopped for either a short oscillator-settling interval or a long supply-settling interval. The CPU is then allowed to run.

Two inputs pick the path and the hold length: a board strap pin and the power-on status bit that firmware keeps. If the strap is high and the bus lines rest in their idle pattern, the device suspends. It waits for a K state, or for SE0 (bus reset shows up as a long SE0), before the hold begins. For the hold length the strap pin has the highest priority. A set status bit comes next. The short interval is the fallback.

All timing runs from a 1 µs tick pulse. The two interval lengths are parameters, counted in ticks.

Top module: `startup_sequencer`

## Requirements
- R1: While `pwrGood` is low, `cpuHold` and `gpioForceIn` are 1 and `suspended` is 0. A fall of `pwrGood` forces this at once, without waiting for a clock edge, and it applies from any state.
- R2: `gpioForceIn` is 1 only in the reset state. It falls at the first clock edge after `pwrGood` goes high and stays 0 until `pwrGood` falls again.
- R3: At the first clock edge after `pwrGood` goes high, if `strapHi` is 1, `lineDm` is 1 and `lineDp` is 0, the block enters suspend. In suspend, `suspended` is 1 and `cpuHold` is 1.
- R4: Suspend ends only when a wake pattern has been sampled at two consecutive clock edges. A wake pattern is a K state (`lineDp`=1, `lineDm`=0) or SE0 (both lines 0). The block leaves suspend at the next edge after the second sample. A pattern seen at a single edge is ignored.
- R5: The hold length is fixed at the edge that enters the hold. If `strapHi` is 1 it is `SHORT_US` ticks. Otherwise, if `porStatus` is 1, it is `LONG_US` ticks. Otherwise it is `SHORT_US` ticks.
- R6: Only `tickUs` pulses sampled while in the hold are counted. Ticks during reset or suspend count for nothing. `cpuHold` falls at the clock edge that samples the last tick of the selected length.
- R7: Once `cpuHold` has fallen it stays 0 until `pwrGood` falls, whatever the bus lines, strap or status bit do.
- R8: If, at the first edge after release, `strapHi` is 0 or the lines are not idle (`lineDm`=1, `lineDp`=0), the block skips suspend and goes straight to the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrGood | input | 1 | Supply good; low is power-on reset (asynchronous, active low) |
| strapHi | input | 1 | Board strap selecting the suspend path and the short delay |
| lineDm | input | 1 | Bus minus data-line level |
| lineDp | input | 1 | Bus plus data-line level |
| porStatus | input | 1 | Power-on status bit as kept by firmware |
| tickUs | input | 1 | One-cycle pulse every microsecond |
| cpuHold | output | 1 | High while the CPU must not run |
| gpioForceIn | output | 1 | High while all GPIO pins are forced to input mode |
| suspended | output | 1 | High while waiting in suspend for a bus wake event |

## Verification
The bench targets four corner cases:
- A single-edge K glitch during suspend. A design that woke on one sample would leave suspend early.
- A strap that drops to low at the moment of wake, with the status bit set. A design that latched the delay choice at release would pick the short hold instead of the long one.
- Tick pulses during suspend. A design that counted them would end the hold early.
- A fall of `pwrGood` in the middle of a cycle. A synchronous-only reset would leave the CPU running for part of a clock period.

Each scenario is compared every cycle against a behavioural model of the state and tick count. Directed checks then confirm that `cpuHold` is still high one tick before the selected count and low right after it.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

  typedef enum logic [1:0] {
    ST_POR  = 2'd0,
    ST_SUSP = 2'd1,
    ST_HOLD = 2'd2,
    ST_RUN  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadShort;
    logic loadLong;
    logic countEn;
  } seqCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic wake;
    logic done;
  } seqSts_t;

endpackage

// File: rtl/startup_seq_counter.sv
module startup_seq_counter #(
  parameter int TERM = 128
) (
  input  logic clk,
  input  logic pwrGood,
  input  logic load,
  input  logic step,
  output logic atLast
);
  localparam int W = (TERM > 1) ? $clog2(TERM) : 1;
  localparam logic [W-1:0] LAST = W'(TERM - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)      cnt <= '0;
    else if (load)     cnt <= '0;
    else if (step && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign atLast = (cnt == LAST);
endmodule

// File: rtl/startup_seq_datapath.sv
module startup_seq_datapath
  import startup_seq_pkg::*;
#(
  parameter int SHORT_US = 128,
  parameter int LONG_US  = 96000
) (
  input  logic    clk,
  input  logic    pwrGood,
  input  logic    tickUs,
  input  logic    lineDm,
  input  logic    lineDp,
  input  seqCtl_t ctl,
  output seqSts_t sts
);
  // two-deep line history, reset to the idle pattern
  logic newDm, newDp, oldDm, oldDp;
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      newDm <= 1'b1; newDp <= 1'b0;
      oldDm <= 1'b1; oldDp <= 1'b0;
    end else begin
      newDm <= lineDm; newDp <= lineDp;
      oldDm <= newDm;  oldDp <= newDp;
    end
  end

  logic kTwice, se0Twice;
  assign kTwice   = newDp & ~newDm & oldDp & ~oldDm;
  assign se0Twice = ~newDp & ~newDm & ~oldDp & ~oldDm;

  // which counter is active
  logic selLong;
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)          selLong <= 1'b0;
    else if (ctl.loadLong) selLong <= 1'b1;
    else if (ctl.loadShort) selLong <= 1'b0;
  end

  logic stepShort, stepLong, lastShort, lastLong;
  assign stepShort = ctl.countEn & tickUs & ~selLong;
  assign stepLong  = ctl.countEn & tickUs & selLong;

  startup_seq_counter #(.TERM(SHORT_US)) u_short (
    .clk(clk), .pwrGood(pwrGood), .load(ctl.loadShort),
    .step(stepShort), .atLast(lastShort)
  );

  startup_seq_counter #(.TERM(LONG_US)) u_long (
    .clk(clk), .pwrGood(pwrGood), .load(ctl.loadLong),
    .step(stepLong), .atLast(lastLong)
  );

  assign sts.wake = kTwice | se0Twice;
  assign sts.done = (stepShort & lastShort) | (stepLong & lastLong);
endmodule

// File: rtl/startup_seq_control.sv
module startup_seq_control
  import startup_seq_pkg::*;
(
  input  logic    clk,
  input  logic    pwrGood,
  input  logic    strapHi,
  input  logic    lineDm,
  input  logic    lineDp,
  input  logic    porStatus,
  input  seqSts_t sts,
  output seqCtl_t ctl,
  output logic    cpuHold,
  output logic    gpioForceIn,
  output logic    suspended
);
  seqState_t state, stateNext;
  logic busIdle, pickLong;

  assign busIdle  = lineDm & ~lineDp;
  assign pickLong = ~strapHi & porStatus;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_POR: begin
        if (strapHi && busIdle) stateNext = ST_SUSP;
        else begin
          stateNext     = ST_HOLD;
          ctl.loadLong  = pickLong;
          ctl.loadShort = ~pickLong;
        end
      end
      ST_SUSP: begin
        if (sts.wake) begin
          stateNext     = ST_HOLD;
          ctl.loadLong  = pickLong;
          ctl.loadShort = ~pickLong;
        end
      end
      ST_HOLD: begin
        ctl.countEn = 1'b1;
        if (sts.done) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) state <= ST_POR;
    else          state <= stateNext;
  end

  assign cpuHold     = (state != ST_RUN);
  assign gpioForceIn = (state == ST_POR);
  assign suspended   = (state == ST_SUSP);
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import startup_seq_pkg::*;
#(
  parameter int SHORT_US = 128,
  parameter int LONG_US  = 96000
) (
  input  logic clk,
  input  logic pwrGood,
  input  logic strapHi,
  input  logic lineDm,
  input  logic lineDp,
  input  logic porStatus,
  input  logic tickUs,
  output logic cpuHold,
  output logic gpioForceIn,
  output logic suspended
);
  seqCtl_t ctl;
  seqSts_t sts;

  startup_seq_control u_ctrl (
    .clk(clk), .pwrGood(pwrGood), .strapHi(strapHi),
    .lineDm(lineDm), .lineDp(lineDp), .porStatus(porStatus),
    .sts(sts), .ctl(ctl), .cpuHold(cpuHold),
    .gpioForceIn(gpioForceIn), .suspended(suspended)
  );

  startup_seq_datapath #(.SHORT_US(SHORT_US), .LONG_US(LONG_US)) u_dp (
    .clk(clk), .pwrGood(pwrGood), .tickUs(tickUs),
    .lineDm(lineDm), .lineDp(lineDp), .ctl(ctl), .sts(sts)
  );
endmodule

// File: rtl/startup_seq_checker.sv
module startup_seq_checker (
  input logic clk,
  input logic pwrGood,
  input logic lineDm,
  input logic lineDp,
  input logic cpuHold,
  input logic gpioForceIn,
  input logic suspended
);
  logic kNow, se0Now;
  assign kNow   = lineDp & ~lineDm;
  assign se0Now = ~lineDp & ~lineDm;

  always @(posedge clk) begin
    if (!pwrGood) begin
      AST_RESET_OUTPUTS: assert (cpuHold && gpioForceIn && !suspended); // R1
    end
  end

  AST_FORCE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!pwrGood)
    gpioForceIn |=> !gpioForceIn); // R2

  AST_SUSPEND_HOLDS_CPU: assert property (@(posedge clk) disable iff (!pwrGood)
    suspended |-> cpuHold); // R3

  AST_WAKE_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!pwrGood)
    $fell(suspended) |->
      (($past(kNow, 2) && $past(kNow, 3)) || ($past(se0Now, 2) && $past(se0Now, 3)))); // R4

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!pwrGood)
    !cpuHold |=> !cpuHold); // R7

  AST_NO_FORCE_IN_SUSPEND: assert property (@(posedge clk) disable iff (!pwrGood)
    !(gpioForceIn && suspended)); // R2
endmodule

bind startup_sequencer startup_seq_checker u_chk (
  .clk(clk), .pwrGood(pwrGood), .lineDm(lineDm), .lineDp(lineDp),
  .cpuHold(cpuHold), .gpioForceIn(gpioForceIn), .suspended(suspended)
);

// File: tb/tb_startup_sequencer.sv
module tb_startup_sequencer;
  localparam int PERIOD = 10;
  localparam int SHORT = 12;
  localparam int LONG  = 40;

  logic clk = 1'b0;
  logic pwrGood = 1'b0, strapHi = 1'b0, lineDm = 1'b1, lineDp = 1'b0;
  logic porStatus = 1'b0, tickUs = 1'b0;
  logic cpuHold, gpioForceIn, suspended;

  int checks = 0;
  int errors = 0;

  startup_sequencer #(.SHORT_US(SHORT), .LONG_US(LONG)) dut (
    .clk(clk), .pwrGood(pwrGood), .strapHi(strapHi), .lineDm(lineDm),
    .lineDp(lineDp), .porStatus(porStatus), .tickUs(tickUs),
    .cpuHold(cpuHold), .gpioForceIn(gpioForceIn), .suspended(suspended)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 reset, 1 suspend, 2 hold, 3 run
  int mSt = 0, mCnt = 0, mTarget = 0, h1 = 0, h2 = 0;

  function automatic int lineClass(logic dm, logic dp);
    if (dm && !dp) return 0;      // idle
    if (!dm && dp) return 1;      // K
    if (!dm && !dp) return 2;     // SE0
    return 3;
  endfunction

  function automatic int pickLen(logic s, logic p);
    if (s) return SHORT;
    if (p) return LONG;
    return SHORT;
  endfunction

  always @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      mSt = 0; mCnt = 0; h1 = 0; h2 = 0;
    end else begin
      case (mSt)
        0: if (strapHi && lineDm && !lineDp) mSt = 1;
           else begin mSt = 2; mCnt = 0; mTarget = pickLen(strapHi, porStatus); end
        1: if ((h1 == 1 && h2 == 1) || (h1 == 2 && h2 == 2)) begin
             mSt = 2; mCnt = 0; mTarget = pickLen(strapHi, porStatus);
           end
        2: if (tickUs) begin mCnt++; if (mCnt == mTarget) mSt = 3; end
        default: ;
      endcase
      h2 = h1;
      h1 = lineClass(lineDm, lineDp);
    end
  end

  always @(posedge clk) begin
    #(PERIOD/4);
    chk("R6", "cpuHold vs model", cpuHold, mSt != 3);
    chk("R2", "gpioForceIn vs model", gpioForceIn, mSt == 0);
    chk("R3", "suspended vs model", suspended, mSt == 1);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tickUs = 1'b1; @(negedge clk);
      tickUs = 1'b0; @(negedge clk);
    end
  endtask

  task automatic dropPower();
    @(negedge clk);
    #(PERIOD/8);
    pwrGood = 1'b0;
    #1;
    chk("R1", "cpuHold async", cpuHold, 1'b1);
    chk("R1", "gpioForceIn async", gpioForceIn, 1'b1);
    chk("R1", "suspended async", suspended, 1'b0);
    cyc(2);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1", "reset cpuHold", cpuHold, 1'b1);
    chk("R1", "reset gpioForceIn", gpioForceIn, 1'b1);
    chk("R1", "reset suspended", suspended, 1'b0);

    // suspend path: strap high, idle bus, status set (strap wins -> short)
    strapHi = 1'b1; porStatus = 1'b1;
    pwrGood = 1'b1;
    cyc(1);
    chk("R2", "force released", gpioForceIn, 1'b0);
    chk("R3", "entered suspend", suspended, 1'b1);
    ticks(5);                               // ticks in suspend are not counted
    lineDm = 1'b0; lineDp = 1'b1; cyc(1);   // single-edge K glitch
    lineDm = 1'b1; lineDp = 1'b0; cyc(4);
    chk("R4", "glitch ignored", suspended, 1'b1);
    lineDm = 1'b0; lineDp = 1'b0; cyc(3);   // SE0 on two edges, then exit
    chk("R4", "SE0 wakes", suspended, 1'b0);
    chk("R4", "hold after wake", cpuHold, 1'b1);
    lineDm = 1'b1;
    ticks(SHORT - 1);
    chk("R5", "strap high: still held one tick short", cpuHold, 1'b1);
    ticks(1);
    chk("R6", "released after SHORT ticks", cpuHold, 1'b0);
    // run is sticky
    strapHi = 1'b0; lineDm = 1'b0; lineDp = 1'b0; cyc(3);
    lineDp = 1'b1; ticks(3);
    chk("R7", "run stays after line activity", cpuHold, 1'b0);

    dropPower();
    // strap low, status set -> long, no suspend
    lineDm = 1'b1; lineDp = 1'b0; strapHi = 1'b0; porStatus = 1'b1;
    pwrGood = 1'b1;
    cyc(1);
    chk("R8", "strap low skips suspend", suspended, 1'b0);
    ticks(LONG - 1);
    chk("R5", "status set: held one tick before LONG", cpuHold, 1'b1);
    ticks(1);
    chk("R6", "released after LONG ticks", cpuHold, 1'b0);

    dropPower();
    // strap low, status clear -> short
    porStatus = 1'b0;
    pwrGood = 1'b1;
    cyc(1);
    ticks(SHORT - 1);
    chk("R5", "status clear: held one tick short", cpuHold, 1'b1);
    ticks(1);
    chk("R5", "status clear: released at SHORT", cpuHold, 1'b0);

    dropPower();
    // strap high but bus shows K -> no suspend, short
    strapHi = 1'b1; porStatus = 1'b1; lineDm = 1'b0; lineDp = 1'b1;
    pwrGood = 1'b1;
    cyc(1);
    chk("R8", "busy bus skips suspend", suspended, 1'b0);
    ticks(SHORT);
    chk("R5", "busy bus strap high gives SHORT", cpuHold, 1'b0);

    dropPower();
    // suspend, then wake by K with strap dropped -> long
    strapHi = 1'b1; porStatus = 1'b1; lineDm = 1'b1; lineDp = 1'b0;
    pwrGood = 1'b1;
    cyc(2);
    chk("R3", "suspend again", suspended, 1'b1);
    lineDm = 1'b0; lineDp = 1'b1; strapHi = 1'b0;
    cyc(2);
    chk("R4", "still suspended before exit edge", suspended, 1'b1);
    cyc(1);
    chk("R4", "K wakes", suspended, 1'b0);
    ticks(LONG - 1);
    chk("R5", "strap low at wake picks LONG", cpuHold, 1'b1);
    ticks(1);
    chk("R6", "released after LONG from wake", cpuHold, 1'b0);

    // power drop in the middle of suspend
    dropPower();
    strapHi = 1'b1; lineDm = 1'b1; lineDp = 1'b0;
    pwrGood = 1'b1;
    cyc(2);
    dropPower();
    chk("R1", "held after drop from suspend", cpuHold, 1'b1);

    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule